// File: doc/BRIEF.md
# Backup-Entry Timestamp Capture

This block records the value of a free-running time counter at the instant the system switches over to backup power. The time counter and the logic that detects the switch-over sit outside the block. The block receives the counter value, a single-cycle pulse that marks each backup entry, a timestamp enable, a low-power enable, a count of ignored low-order bits, and a clear-status command. It drives the stored timestamp and a sticky valid flag.

A stamp is taken only once. After the first permitted capture, the valid flag locks the register. Later entry pulses, for example from a supply that bounces in and out of backup, leave the stored value alone until software issues a clear. When the low-power mode is enabled, the counter's low-order bits that this mode does not use are written as zero instead of being stored.

Top module: `backup_stamp_capture`

## Requirements
- R1: After synchronous reset, `stamp` is 0 and `stamp_valid` is 0.
- R2: When `bu_entry` is 1 and `ts_en` is 1 while `stamp_valid` is 0, `stamp` holds the (masked) `cnt_value` of that cycle and `stamp_valid` is 1 from the next clock edge.
- R3: An entry pulse with `ts_en` at 0 changes neither `stamp` nor `stamp_valid`.
- R4: While `stamp_valid` is 1 and `clr_status` is 0, an entry pulse leaves `stamp` unchanged and `stamp_valid` at 1.
- R5: `clr_status` at 1 with no permitted entry in the same cycle clears `stamp_valid` at the next edge and leaves `stamp` unchanged.
- R6: When `clr_status` and a permitted entry (`bu_entry` and `ts_en` both 1) occur in the same cycle, the clear acts first. A new stamp is captured and `stamp_valid` stays 1.
- R7: When `lp_en` is 1 at capture, bits [`lp_ign`-1:0] of the stored stamp are 0 and the higher bits equal `cnt_value`. `lp_ign` is an unsigned count from 0 to 7, and a count of 0 keeps every bit.
- R8: When `lp_en` is 0 at capture, every bit of `cnt_value` is stored, whatever the value of `lp_ign`.
- R9: Without a permitted capture, `stamp` keeps its value while `cnt_value` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_value | input | CNT_W | Current value of the free-running counter |
| bu_entry | input | 1 | One-cycle pulse marking entry into backup mode |
| ts_en | input | 1 | Timestamp enable |
| lp_en | input | 1 | Low-power mode enable |
| lp_ign | input | IGN_W | Number of ignored low-order bits in low-power mode |
| clr_status | input | 1 | Clear-status command, active 1 |
| stamp | output | CNT_W | Stored timestamp |
| stamp_valid | output | 1 | Sticky flag, set when a stamp has been stored |

## Verification
The bench builds the block with its default sizes: a 32-bit counter and a 3-bit ignored-bit count. With these sizes, every ignored-bit setting from 0 to 7 can be captured in turn against an all-ones counter value, so each mask boundary is visible at the output. A 32-bit stamp also makes it easy to tell a stale value from a fresh one when the bench checks locking, clearing and the case where a clear and an entry arrive in the same cycle.

// File: rtl/bkts_pkg.sv
package bkts_pkg;
  localparam int unsigned BKTS_CNT_W = 32;
  localparam int unsigned BKTS_IGN_W = 3;

  typedef enum logic [1:0] {
    BKTS_IDLE    = 2'b00,
    BKTS_CAPTURE = 2'b01,
    BKTS_LOCKED  = 2'b10
  } bkts_evt_e;
endpackage

// File: rtl/bkts_mask_gen.sv
module bkts_mask_gen #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IGN_W = 3
) (
  input  logic             lp_en,
  input  logic [IGN_W-1:0] lp_ign,
  output logic [CNT_W-1:0] keep_mask
);
  localparam int unsigned IGN_MAX = (1 << IGN_W) - 1;

  logic [31:0] ign_cnt;
  assign ign_cnt = 32'(lp_ign);

  for (genvar g = 0; g < CNT_W; g++) begin : g_bit
    if (g < IGN_MAX) begin : g_maskable
      assign keep_mask[g] = ~(lp_en & (ign_cnt > 32'(g)));
    end else begin : g_fixed
      assign keep_mask[g] = 1'b1;
    end
  end
endmodule

// File: rtl/bkts_capture_ctrl.sv
module bkts_capture_ctrl
  import bkts_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bu_entry,
  input  logic ts_en,
  input  logic clr_status,
  output logic capture,
  output logic valid_q
);
  bkts_evt_e evt;
  logic      unlocked;

  // A clear in the same cycle releases the lock before the entry is judged.
  assign unlocked = ~valid_q | clr_status;

  always_comb begin
    evt = BKTS_IDLE;
    if (bu_entry && ts_en) begin
      evt = unlocked ? BKTS_CAPTURE : BKTS_LOCKED;
    end
  end

  assign capture = (evt == BKTS_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (capture) begin
      valid_q <= 1'b1;
    end else if (clr_status) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bkts_stamp_reg.sv
module bkts_stamp_reg #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/backup_stamp_capture.sv
module backup_stamp_capture
  import bkts_pkg::*;
#(
  parameter int unsigned CNT_W = BKTS_CNT_W,
  parameter int unsigned IGN_W = BKTS_IGN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             bu_entry,
  input  logic             ts_en,
  input  logic             lp_en,
  input  logic [IGN_W-1:0] lp_ign,
  input  logic             clr_status,
  output logic [CNT_W-1:0] stamp,
  output logic             stamp_valid
);
  logic [CNT_W-1:0] keep_mask;
  logic             capture;

  bkts_mask_gen #(.CNT_W(CNT_W), .IGN_W(IGN_W)) u_mask (
    .lp_en     (lp_en),
    .lp_ign    (lp_ign),
    .keep_mask (keep_mask)
  );

  bkts_capture_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .bu_entry   (bu_entry),
    .ts_en      (ts_en),
    .clr_status (clr_status),
    .capture    (capture),
    .valid_q    (stamp_valid)
  );

  bkts_stamp_reg #(.CNT_W(CNT_W)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (capture),
    .din  (cnt_value & keep_mask),
    .dout (stamp)
  );
endmodule

// File: rtl/bkts_checker.sv
module bkts_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IGN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_value,
  input logic             bu_entry,
  input logic             ts_en,
  input logic             lp_en,
  input logic [IGN_W-1:0] lp_ign,
  input logic             clr_status,
  input logic [CNT_W-1:0] stamp,
  input logic             stamp_valid
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (stamp == '0) && !stamp_valid);

  assert_capture_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (bu_entry && ts_en && !stamp_valid) |=> stamp_valid);

  assert_disabled_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bu_entry && !ts_en && !clr_status) |=> $stable(stamp) && $stable(stamp_valid));

  assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (stamp_valid && !clr_status) |=> $stable(stamp) && stamp_valid);

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_status && !(bu_entry && ts_en)) |=> !stamp_valid && $stable(stamp));

  assert_clear_then_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_status && bu_entry && ts_en) |=> stamp_valid);

  assert_lowbit_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bu_entry && ts_en && !stamp_valid && lp_en && (lp_ign != '0)) |=> (stamp[0] == 1'b0));

  assert_full_store_R8: assert property (@(posedge clk) disable iff (rst)
    (bu_entry && ts_en && !stamp_valid && !lp_en) |=> (stamp == $past(cnt_value)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(bu_entry && ts_en) |=> $stable(stamp));
endmodule

bind backup_stamp_capture bkts_checker #(.CNT_W(CNT_W), .IGN_W(IGN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_value   (cnt_value),
  .bu_entry    (bu_entry),
  .ts_en       (ts_en),
  .lp_en       (lp_en),
  .lp_ign      (lp_ign),
  .clr_status  (clr_status),
  .stamp       (stamp),
  .stamp_valid (stamp_valid)
);

// File: tb/backup_stamp_capture_bench.sv
module backup_stamp_capture_bench;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned IGN_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] cnt_value;
  logic             bu_entry, ts_en, lp_en, clr_status;
  logic [IGN_W-1:0] lp_ign;
  logic [CNT_W-1:0] stamp;
  logic             stamp_valid;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  backup_stamp_capture #(.CNT_W(CNT_W), .IGN_W(IGN_W)) u_backup_stamp_capture (
    .clk(clk), .rst(rst), .cnt_value(cnt_value), .bu_entry(bu_entry),
    .ts_en(ts_en), .lp_en(lp_en), .lp_ign(lp_ign), .clr_status(clr_status),
    .stamp(stamp), .stamp_valid(stamp_valid)
  );

  task automatic check(input string req, input logic [CNT_W-1:0] exp_stamp,
                       input logic exp_valid);
    n_checks++;
    if (stamp !== exp_stamp || stamp_valid !== exp_valid) begin
      n_fails++;
      $display("FAIL %s: stamp=%h valid=%b expected stamp=%h valid=%b",
               req, stamp, stamp_valid, exp_stamp, exp_valid);
    end
  endtask

  // Drive one cycle of stimulus on a falling edge, release it on the next one.
  task automatic step(input logic [CNT_W-1:0] cv, input logic ent, input logic en,
                      input logic clr);
    @(negedge clk);
    cnt_value = cv; bu_entry = ent; ts_en = en; clr_status = clr;
    @(negedge clk);
    bu_entry = 1'b0; clr_status = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; cnt_value = '0; bu_entry = 0; ts_en = 0; lp_en = 0;
    lp_ign = '0; clr_status = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_basic_capture;
    ts_en = 1'b1;
    step(32'hA5A5_1234, 1'b1, 1'b1, 1'b0);
    check("R2 capture", 32'hA5A5_1234, 1'b1);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cnt_value = 32'h0000_1000 + i;
    end
    @(negedge clk);
    check("R9 hold", 32'hA5A5_1234, 1'b1);
  endtask

  task automatic t_locked;
    step(32'h1111_2222, 1'b1, 1'b1, 1'b0);
    check("R4 locked", 32'hA5A5_1234, 1'b1);
    step(32'h3333_4444, 1'b1, 1'b1, 1'b0);
    check("R4 locked twice", 32'hA5A5_1234, 1'b1);
  endtask

  task automatic t_clear;
    step(32'h5555_6666, 1'b0, 1'b1, 1'b1);
    check("R5 clear", 32'hA5A5_1234, 1'b0);
  endtask

  task automatic t_disabled;
    step(32'h7777_8888, 1'b1, 1'b0, 1'b0);
    check("R3 disabled", 32'hA5A5_1234, 1'b0);
    step(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
    check("R2 capture after clear", 32'hDEAD_BEEF, 1'b1);
  endtask

  task automatic t_clear_and_entry;
    step(32'hCAFE_0001, 1'b1, 1'b1, 1'b1);
    check("R6 clear+entry", 32'hCAFE_0001, 1'b1);
  endtask

  task automatic t_lowpower;
    lp_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(32'h0, 1'b0, 1'b1, 1'b1);
      lp_ign = IGN_W'(k);
      step(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
      check($sformatf("R7 lp ign=%0d", k), 32'hFFFF_FFFF << k, 1'b1);
    end
  endtask

  task automatic t_lp_off;
    step(32'h0, 1'b0, 1'b1, 1'b1);
    lp_en = 1'b0; lp_ign = 3'd5;
    step(32'h0000_00FF, 1'b1, 1'b1, 1'b0);
    check("R8 lp off", 32'h0000_00FF, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_capture();
    t_hold();
    t_locked();
    t_clear();
    t_disabled();
    t_clear_and_entry();
    t_lowpower();
    t_lp_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule